// File: doc/BRIEF.md
# Store Buffer with Load Forwarding and Write Barrier

This block sits between a processor's store port and its data cache. A store is written into a small FIFO at once, even while the coherence logic is still collecting invalidate acknowledgements for the target line. The oldest entry is shown to the cache on a valid/ready channel. It is only presented once the coherence side raises `line_owned`, which means ownership of that entry's line, shown on `cache_addr`, has been obtained. Entries leave strictly in arrival order, at most one per cycle.

Loads search the buffer in parallel with the cache. When an address matches, the buffer returns the data of the youngest matching store, so the processor always sees its own latest write. A write-barrier pulse marks every entry present at that edge. Stores that arrive later may still enter the buffer, but they reach the cache only after every marked entry has drained. While marked entries remain, `barrier_busy` stays high so the issuing side can see the barrier has not yet retired.

Top module: `stbuf_top`

## Requirements
- R1: After a synchronous reset the buffer is empty: `st_ready`=1, `cache_valid`=0, `ld_hit`=0, `ld_data`=0, `barrier_busy`=0.
- R2: A store is accepted on any rising edge where `st_valid` and `st_ready` are both high, whatever the state of `line_owned` and `cache_ready`. `st_ready` is high exactly when fewer than DEPTH entries are held.
- R3: With DEPTH entries held, `st_ready` is low and an offered store is dropped. It never appears on the cache side. A store is not accepted in the same cycle that frees a slot from a full buffer.
- R4: `cache_valid` is high exactly when the buffer is non-empty and `line_owned` is high. Whenever the buffer is non-empty, `cache_addr` and `cache_data` show the oldest entry.
- R5: An entry leaves on an edge where `cache_valid` and `cache_ready` are both high, one per edge, in acceptance order. While `cache_valid` is high and `cache_ready` is low, `cache_addr` and `cache_data` do not change.
- R6: `ld_hit` and `ld_data` are registered. After an edge they report the search of `ld_addr` against the entries held just before that edge. On a miss, `ld_hit`=0 and `ld_data`=0.
- R7: When several held entries match the load address, `ld_data` is the data of the most recently accepted one.
- R8: A `wr_barrier` pulse marks every entry held at that edge, including one that drains on the same edge. A store accepted on that edge is not marked. `barrier_busy` is high while any marked entry remains, and entries accepted later cannot drain before the marked ones.
- R9: A barrier given while no entry is held has no effect: `barrier_busy` stays low and stores are accepted without stall.
- R10: A barrier given while marks are still outstanding marks every entry then held. `barrier_busy` falls only when the last of them has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer has a free slot |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| wr_barrier | input | 1 | Write-barrier pulse |
| barrier_busy | output | 1 | Marked entries still held |
| ld_addr | input | AW | Load address to search |
| ld_hit | output | 1 | Registered: a held entry matched |
| ld_data | output | DW | Registered: youngest matching data, 0 on miss |
| line_owned | input | 1 | Ownership of the oldest entry's line is obtained |
| cache_valid | output | 1 | Oldest entry offered to the cache |
| cache_ready | input | 1 | Cache accepts the offered entry |
| cache_addr | output | AW | Oldest entry address |
| cache_data | output | DW | Oldest entry data |

## Verification
The bench targets several corner cases:
- Loads against a buffer holding repeated addresses. A search that runs oldest-last, or ignores the wrap of the pointers, returns stale data for the youngest match.
- A store offered to a full buffer. A design that did not drop it would overwrite the oldest entry and corrupt the drain order.
- A barrier coinciding with a store, and with a drain. A design that marked the incoming store, or lost the draining mark, would hold `barrier_busy` one entry too long or too short.
- A second barrier issued while marks are still outstanding, which must extend the marked set rather than replace it.

All inputs are also driven by a pseudo-random sweep against an arithmetic queue model.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  // Buffer operation in one cycle, encoded as {push, pop}.
  typedef enum logic [1:0] {
    SB_IDLE = 2'b00,
    SB_POP  = 2'b01,
    SB_PUSH = 2'b10,
    SB_BOTH = 2'b11
  } sb_op_t;
endpackage

// File: rtl/stbuf_store.sv
module stbuf_store
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          bar,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] ent_addr [DEPTH],
  output logic [DW-1:0] ent_data [DEPTH],
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] cnt,
  output logic          busy
);
  logic [PW-1:0]    wr_ptr;
  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] mark;
  sb_op_t           op;

  assign op = sb_op_t'({push, pop});

  // An entry is held when its distance from the head is below the count.
  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    logic [PW-1:0] age;
    assign age    = PW'(g) - rd_ptr;
    assign occ[g] = CW'(age) < cnt;
  end

  assign busy = |(mark & occ);

  // Entry storage: data only, no reset.
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[wr_ptr] <= wr_addr;
      ent_data[wr_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bar && occ[i]) mark[i] <= 1'b1;
      end
      if (push) mark[wr_ptr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case (op)
        SB_PUSH: cnt <= cnt + CW'(1);
        SB_POP:  cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH) && !pop) |=> cnt == CW'(DEPTH));
  a_r2_accept_grows: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> cnt == $past(cnt) + CW'(1));
  a_r8_barrier_marks: assert property (@(posedge clk) disable iff (rst)
    (bar && cnt > CW'(1)) |=> busy);
  a_r9_idle_barrier: assert property (@(posedge clk) disable iff (rst)
    (bar && cnt == '0 && !busy) |=> !busy);
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ent_addr [DEPTH],
  input  logic [DW-1:0] ent_data [DEPTH],
  input  logic [PW-1:0] rd_ptr,
  input  logic [CW-1:0] cnt,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data
);
  logic          hit_c;
  logic [DW-1:0] data_c;
  logic [PW-1:0] idx;

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit_c  = 1'b0;
    data_c = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_ptr + PW'(k);
      if (CW'(k) < cnt && ent_addr[idx] == ld_addr) begin
        hit_c  = 1'b1;
        data_c = ent_data[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end else begin
      ld_hit  <= hit_c;
      ld_data <= data_c;
    end
  end

  a_r6_hit_needs_entry: assert property (@(posedge clk) disable iff (rst)
    ld_hit |-> $past(cnt) != '0);
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          wr_barrier,
  output logic          barrier_busy,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          line_owned,
  output logic          cache_valid,
  input  logic          cache_ready,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_data
);
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cnt;
  logic          push;
  logic          pop;

  assign st_ready    = cnt != CW'(DEPTH);
  assign push        = st_valid && st_ready;
  assign cache_valid = line_owned && (cnt != '0);
  assign pop         = cache_valid && cache_ready;
  assign cache_addr  = ent_addr[rd_ptr];
  assign cache_data  = ent_data[rd_ptr];

  stbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) store_i (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .bar      (wr_barrier),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .rd_ptr   (rd_ptr),
    .cnt      (cnt),
    .busy     (barrier_busy)
  );

  stbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fwd_i (
    .clk      (clk),
    .rst      (rst),
    .ld_addr  (ld_addr),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .rd_ptr   (rd_ptr),
    .cnt      (cnt),
    .ld_hit   (ld_hit),
    .ld_data  (ld_data)
  );

  a_r5_head_hold: assert property (@(posedge clk) disable iff (rst)
    (cache_valid && !cache_ready) |=> $stable(cache_addr) && $stable(cache_data));
  a_r4_valid_needs_entry: assert property (@(posedge clk) disable iff (rst)
    (!st_ready && !pop) |=> cnt != '0);
endmodule

// File: tb/stbuf_top_tb_top.sv
module stbuf_top_tb_top;
  localparam int CLK_P = 10;
  localparam int TDEP  = 4;
  localparam int TA    = 4;
  localparam int TD    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [TA-1:0] st_addr = '0;
  logic [TD-1:0] st_data = '0;
  logic          wr_barrier = 1'b0;
  logic          barrier_busy;
  logic [TA-1:0] ld_addr = '0;
  logic          ld_hit;
  logic [TD-1:0] ld_data;
  logic          line_owned = 1'b0;
  logic          cache_valid;
  logic          cache_ready = 1'b0;
  logic [TA-1:0] cache_addr;
  logic [TD-1:0] cache_data;

  int total = 0;
  int bad   = 0;
  logic [TA-1:0] qa[$];
  logic [TD-1:0] qd[$];
  int mcnt = 0;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  stbuf_top #(.DEPTH(TDEP), .AW(TA), .DW(TD)) dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .wr_barrier(wr_barrier),
    .barrier_busy(barrier_busy), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_data(ld_data), .line_owned(line_owned), .cache_valid(cache_valid),
    .cache_ready(cache_ready), .cache_addr(cache_addr), .cache_data(cache_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic drv(input bit sv, input int a, input int d, input bit br,
                     input bit own, input bit rdy, input int la);
    st_valid    = sv;
    st_addr     = TA'(a);
    st_data     = TD'(d);
    wr_barrier  = br;
    line_owned  = own;
    cache_ready = rdy;
    ld_addr     = TA'(la);
  endtask

  // One clock: predict from the model, advance, then compare at the falling edge.
  task automatic step();
    int  n    = qa.size();
    bit  push = st_valid && n < TDEP;
    bit  pop  = line_owned && cache_ready && n > 0;
    bit  eh   = 1'b0;
    int  ed   = 0;
    int  m    = wr_barrier ? n : mcnt;
    for (int i = 0; i < n; i++) begin
      if (qa[i] == ld_addr) begin
        eh = 1'b1;
        ed = int'(qd[i]);
      end
    end
    if (pop && m > 0) m--;
    @(posedge clk);
    if (pop) begin
      void'(qa.pop_front());
      void'(qd.pop_front());
    end
    if (push) begin
      qa.push_back(st_addr);
      qd.push_back(st_data);
    end
    mcnt = m;
    @(negedge clk);
    chk("R2 st_ready", int'(st_ready), int'(qa.size() < TDEP));
    chk("R4 cache_valid", int'(cache_valid), int'(line_owned && qa.size() > 0));
    if (qa.size() > 0) begin
      chk("R5 head addr", int'(cache_addr), int'(qa[0]));
      chk("R5 head data", int'(cache_data), int'(qd[0]));
    end
    chk("R8 barrier_busy", int'(barrier_busy), int'(mcnt > 0));
    chk(eh ? "R7 ld_hit" : "R6 ld_hit", int'(ld_hit), int'(eh));
    chk(eh ? "R7 ld_data" : "R6 ld_data", int'(ld_data), ed);
  endtask

  task automatic drain_all();
    while (qa.size() > 0) begin
      drv(0, 0, 0, 0, 1, 1, 0);
      step();
    end
    drv(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 st_ready", int'(st_ready), 1);
    chk("R1 cache_valid", int'(cache_valid), 0);
    chk("R1 ld_hit", int'(ld_hit), 0);
    chk("R1 ld_data", int'(ld_data), 0);
    chk("R1 barrier_busy", int'(barrier_busy), 0);

    // R9 barrier on an empty buffer, then a store the same cycle
    drv(0, 0, 0, 1, 0, 0, 0); step();
    chk("R9 idle barrier", int'(barrier_busy), 0);
    drv(1, 3, 33, 1, 0, 0, 3); step();
    chk("R9 store not marked", int'(barrier_busy), 0);
    drain_all();

    // R2/R3 fill without ownership, duplicate addresses, then overflow attempt
    for (int i = 0; i < TDEP; i++) begin
      drv(1, i % 2, 16 + i, 0, 0, 0, i % 2); step();
    end
    chk("R3 full", int'(st_ready), 0);
    drv(1, 1, 99, 0, 1, 0, 1); step();
    chk("R3 dropped store", int'(ld_data), 16 + TDEP - 1);
    // R6/R7 load sweep over every address
    for (int a = 0; a < (1 << TA); a++) begin
      drv(0, 0, 0, 0, 0, 0, a); step();
    end
    drain_all();

    // R8 barrier at each fill level, with a store and a drain in the same cycle
    for (int f = 0; f <= TDEP; f++) begin
      for (int i = 0; i < f; i++) begin
        drv(1, i, 40 + i, 0, 0, 0, i); step();
      end
      drv(1, 7, 77, 1, 1, 1, 7); step();
      chk("R8 marks held entries", int'(barrier_busy), int'(f > 1));
      drv(1, 8, 88, 0, 0, 0, 8); step();
      drain_all();
      chk("R8 busy clear", int'(barrier_busy), 0);
    end

    // R10 second barrier extends the marked set
    drv(1, 1, 1, 0, 0, 0, 0); step();
    drv(0, 0, 0, 1, 0, 0, 0); step();
    drv(1, 2, 2, 0, 0, 0, 0); step();
    drv(1, 3, 3, 0, 0, 0, 0); step();
    drv(0, 0, 0, 1, 0, 0, 0); step();
    drv(0, 0, 0, 0, 1, 1, 0); step();
    drv(0, 0, 0, 0, 1, 1, 0); step();
    chk("R10 still busy", int'(barrier_busy), 1);
    drv(0, 0, 0, 0, 1, 1, 0); step();
    chk("R10 busy falls", int'(barrier_busy), 0);
    drain_all();

    // Pseudo-random sweep of every input
    for (int c = 0; c < 2000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drv(lf[0], int'(lf[5:4]), int'(lf[15:8]), lf[1] & lf[2] & lf[3],
          lf[6] | lf[7], lf[3] | lf[9], int'(lf[11:10]));
      step();
    end
    drain_all();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule